// File: doc/BRIEF.md
# Configuration Memory CRC Scrubber with Serial Readout

This block watches a configuration memory image for single-event upsets. In its own checker clock domain it walks the image one 32-bit word per cycle, presenting the word index on `cfg_addr`. It folds each returned word into a running CRC-32. At the end of every pass it latches the finished signature and compares it with a stored reference CRC. It then starts the next pass at once. A mismatch sets an error flag that stays set until the checker domain is reset. The flag belongs to the checker clock domain.

User logic reads either value through a 32-bit serial readout register clocked by the user clock. Driving the shift/load control low for two consecutive user clocks parallel-loads the register. The select input picks either the stored reference or the latest signature. Driving the control high then moves the contents out, one bit per clock, most significant bit first. Each finished signature crosses into the user domain through a toggle handshake, so a load never captures a signature that is only partly updated.

Top module: `cfg_crc_scrub`

## Requirements
- R1: The signature is the reflected CRC-32 over words 0 to NWORDS-1 in index order, with polynomial 0xEDB88320, initial value 0xFFFFFFFF and final XOR 0xFFFFFFFF. Bit 0 of each word enters first, which equals feeding its byte 0 first. The next pass restarts from the initial value.
- R2: On a user-clock edge with `rd_shift`=1, the readout register moves one place toward its MSB and a zero enters at bit 0. `rd_bit` always shows the register's bit 31.
- R3: On the second and every later consecutive user-clock edge with `rd_shift`=0, the register loads one of two values. With `rd_src`=0 it loads `golden_crc`. With `rd_src`=1 it loads the latest signature that has arrived in the user domain.
- R4: An edge with `rd_shift`=0 that follows an edge with `rd_shift`=1 does not load. The register holds its value on that edge.
- R5: `rd_src` has no effect on edges where `rd_shift`=1.
- R6: `crc_err` rises after a pass whose signature differs from `golden_crc`. It stays low while every pass matches.
- R7: Once set, `crc_err` stays high until `chk_rst_n` is asserted, even if later passes match.
- R8: Reset clears the user-domain signature, the readout register and `crc_err` to zero.
- R9: Bit 31 of a loaded value is on `rd_bit` right after the load edge. All 32 bits are presented after 31 further shift edges.
- R10: A load with `rd_src`=1 returns one complete pass signature, never a mix of two passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| chk_clk | input | 1 | Checker oscillator clock |
| chk_rst_n | input | 1 | Active-low asynchronous reset, checker domain |
| cfg_word | input | 32 | Configuration word at index `cfg_addr` |
| golden_crc | input | 32 | Stored reference CRC, quasi-static |
| cfg_addr | output | AW | Index of the word being checked |
| crc_err | output | 1 | Sticky mismatch flag, checker domain |
| usr_clk | input | 1 | User readout clock |
| usr_rst_n | input | 1 | Active-low asynchronous reset, user domain |
| rd_shift | input | 1 | 1 shifts the readout register, 0 requests a load |
| rd_src | input | 1 | Load select: 0 reference, 1 signature |
| rd_bit | output | 1 | Serial readout, MSB of the register |

## Verification
The bench drives the control with a single-cycle low pulse in the middle of a shift-out. A design that loads on the first low edge would jump to a fresh value instead of holding its bit. It also toggles the select on every shift edge. A design that looks at the select while shifting would then corrupt the stream. A readout issued right after reset must return zeros. After that, the bench corrupts one image bit, checks that the flag rises and the read-back signature matches the corrupted image, and then removes the corruption. A flag that was not sticky would then fall, and a signature path that did not restart each pass would never return to the reference value.

// File: rtl/crc_scrub_pkg.sv
package crc_scrub_pkg;
  localparam int          SIG_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_XOUT = 32'hFFFF_FFFF;

  // One full word folded into a reflected CRC, LSB first.
  function automatic logic [31:0] crc_fold_word(input logic [31:0] crc,
                                                input logic [31:0] data);
    logic [31:0] c;
    c = crc ^ data;
    for (int i = 0; i < 32; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/scrub_rst_sync.sv
module scrub_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/scrub_crc_accum.sv
module scrub_crc_accum
  import crc_scrub_pkg::*;
#(
  parameter int NWORDS = 1024,
  parameter int AW     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      word,
  input  logic [31:0]      golden,
  output logic [AW-1:0]    addr,
  output logic [SIG_W-1:0] sig,
  output logic             sig_tog,
  output logic             err
);
  localparam logic [AW-1:0] LAST = AW'(NWORDS - 1);

  logic [31:0]   crc_q, crc_nx, folded, final_sig;
  logic [AW-1:0] cnt_q, cnt_nx;
  logic [31:0]   sig_q, sig_nx;
  logic          tog_q, tog_nx, err_q, err_nx;

  assign folded    = crc_fold_word(crc_q, word);
  assign final_sig = folded ^ CRC_XOUT;

  always_comb begin
    crc_nx = folded;
    cnt_nx = cnt_q + 1'b1;
    sig_nx = sig_q;
    tog_nx = tog_q;
    err_nx = err_q;
    if (cnt_q == LAST) begin
      crc_nx = CRC_INIT;
      cnt_nx = '0;
      sig_nx = final_sig;
      tog_nx = ~tog_q;
      if (final_sig != golden) err_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_INIT;
      cnt_q <= '0;
      sig_q <= '0;
      tog_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      crc_q <= crc_nx;
      cnt_q <= cnt_nx;
      sig_q <= sig_nx;
      tog_q <= tog_nx;
      err_q <= err_nx;
    end
  end

  assign addr    = cnt_q;
  assign sig     = sig_q;
  assign sig_tog = tog_q;
  assign err     = err_q;
endmodule

// File: rtl/scrub_sig_cdc.sv
module scrub_sig_cdc
  import crc_scrub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tog_in,
  input  logic [SIG_W-1:0] sig_in,
  output logic [SIG_W-1:0] sig_out
);
  logic             sync1_q, sync2_q, seen_q;
  logic             cap_en;
  logic [SIG_W-1:0] hold_q, hold_nx;

  assign cap_en  = sync2_q ^ seen_q;
  assign hold_nx = cap_en ? sig_in : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      seen_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      sync1_q <= tog_in;
      sync2_q <= sync1_q;
      seen_q  <= sync2_q;
      hold_q  <= hold_nx;
    end
  end

  assign sig_out = hold_q;
endmodule

// File: rtl/scrub_readout_sr.sv
module scrub_readout_sr
  import crc_scrub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             src,
  input  logic [SIG_W-1:0] golden,
  input  logic [SIG_W-1:0] sig,
  output logic [SIG_W-1:0] sr
);
  logic             low_q;
  logic [SIG_W-1:0] sr_q, sr_nx;

  always_comb begin
    sr_nx = sr_q;
    if (shift)      sr_nx = {sr_q[SIG_W-2:0], 1'b0};
    else if (low_q) sr_nx = src ? sig : golden;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      sr_q  <= '0;
    end else begin
      low_q <= ~shift;
      sr_q  <= sr_nx;
    end
  end

  assign sr = sr_q;
endmodule

// File: rtl/cfg_crc_scrub.sv
module cfg_crc_scrub
  import crc_scrub_pkg::*;
#(
  parameter  int NWORDS = 1024,
  localparam int AW     = (NWORDS > 2) ? $clog2(NWORDS) : 1
) (
  input  logic          chk_clk,
  input  logic          chk_rst_n,
  input  logic [31:0]   cfg_word,
  input  logic [31:0]   golden_crc,
  output logic [AW-1:0] cfg_addr,
  output logic          crc_err,
  input  logic          usr_clk,
  input  logic          usr_rst_n,
  input  logic          rd_shift,
  input  logic          rd_src,
  output logic          rd_bit
);
  logic             chk_rst_sn, usr_rst_sn;
  logic [SIG_W-1:0] chk_sig, usr_sig, rd_reg;
  logic             chk_tog;

  scrub_rst_sync u_chk_rst (.clk(chk_clk), .arst_n(chk_rst_n), .rst_n(chk_rst_sn));
  scrub_rst_sync u_usr_rst (.clk(usr_clk), .arst_n(usr_rst_n), .rst_n(usr_rst_sn));

  scrub_crc_accum #(.NWORDS(NWORDS), .AW(AW)) u_accum (
    .clk(chk_clk), .rst_n(chk_rst_sn), .word(cfg_word), .golden(golden_crc),
    .addr(cfg_addr), .sig(chk_sig), .sig_tog(chk_tog), .err(crc_err)
  );

  scrub_sig_cdc u_cdc (
    .clk(usr_clk), .rst_n(usr_rst_sn), .tog_in(chk_tog),
    .sig_in(chk_sig), .sig_out(usr_sig)
  );

  scrub_readout_sr u_rd (
    .clk(usr_clk), .rst_n(usr_rst_sn), .shift(rd_shift), .src(rd_src),
    .golden(golden_crc), .sig(usr_sig), .sr(rd_reg)
  );

  assign rd_bit = rd_reg[SIG_W-1];
endmodule

// File: rtl/cfg_crc_scrub_chk.sv
module cfg_crc_scrub_chk (
  input logic        usr_clk,
  input logic        usr_rst_sn,
  input logic        chk_clk,
  input logic        chk_rst_sn,
  input logic        rd_shift,
  input logic        rd_src,
  input logic [31:0] golden_crc,
  input logic [31:0] usr_sig,
  input logic [31:0] rd_reg,
  input logic        crc_err
);
  a_r2_shift_zero_fill: assert property (@(posedge usr_clk) disable iff (!usr_rst_sn)
    rd_shift |=> rd_reg == {$past(rd_reg[30:0]), 1'b0});

  a_r3_load_golden: assert property (@(posedge usr_clk) disable iff (!usr_rst_sn)
    !rd_shift ##1 (!rd_shift && !rd_src) |=> rd_reg == $past(golden_crc));

  a_r3_load_signature: assert property (@(posedge usr_clk) disable iff (!usr_rst_sn)
    !rd_shift ##1 (!rd_shift && rd_src) |=> rd_reg == $past(usr_sig));

  a_r4_first_low_holds: assert property (@(posedge usr_clk) disable iff (!usr_rst_sn)
    rd_shift ##1 !rd_shift |=> $stable(rd_reg));

  a_r7_err_sticky: assert property (@(posedge chk_clk) disable iff (!chk_rst_sn)
    crc_err |=> crc_err);
endmodule

bind cfg_crc_scrub cfg_crc_scrub_chk u_chk (
  .usr_clk(usr_clk), .usr_rst_sn(usr_rst_sn), .chk_clk(chk_clk), .chk_rst_sn(chk_rst_sn),
  .rd_shift(rd_shift), .rd_src(rd_src), .golden_crc(golden_crc), .usr_sig(usr_sig),
  .rd_reg(rd_reg), .crc_err(crc_err)
);

// File: tb/cfg_crc_scrub_bench.sv
module cfg_crc_scrub_bench;
  localparam int CLK_PERIOD = 14;
  localparam int CHK_HALF   = 5;
  localparam int NW         = 16;
  localparam int AWB        = $clog2(NW);

  logic            chk_clk = 1'b0, usr_clk = 1'b0;
  logic            chk_rst_n, usr_rst_n;
  logic [31:0]     cfg_word, golden_crc;
  logic [AWB-1:0]  cfg_addr;
  logic            crc_err, rd_shift, rd_src, rd_bit;
  logic            corrupt, run;
  logic [31:0]     exp_sig, m_sr;
  logic            m_prev;
  int              n_chk = 0, n_fail = 0;
  bit              done = 0;

  always #(CHK_HALF) chk_clk = ~chk_clk;
  always #(CLK_PERIOD/2) usr_clk = ~usr_clk;

  cfg_crc_scrub #(.NWORDS(NW)) u_cfg_crc_scrub (
    .chk_clk(chk_clk), .chk_rst_n(chk_rst_n), .cfg_word(cfg_word), .golden_crc(golden_crc),
    .cfg_addr(cfg_addr), .crc_err(crc_err), .usr_clk(usr_clk), .usr_rst_n(usr_rst_n),
    .rd_shift(rd_shift), .rd_src(rd_src), .rd_bit(rd_bit)
  );

  function automatic logic [31:0] image(input int a, input logic bad);
    logic [31:0] w;
    w = (32'(a) + 32'd1) * 32'h9E37_79B9 ^ (32'(a) << 20);
    if (bad && a == 5) w ^= 32'h0000_2000;
    return w;
  endfunction

  // Byte-at-a-time reference CRC over the whole image.
  function automatic logic [31:0] ref_crc(input logic bad);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int a = 0; a < NW; a++) begin
      logic [31:0] w = image(a, bad);
      for (int b = 0; b < 4; b++) begin
        c[7:0] ^= w[8*b +: 8];
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
    end
    return ~c;
  endfunction

  always_comb cfg_word = image(int'(cfg_addr), corrupt);

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Behavioural readout model: held-low count, selected value, shift.
  always @(posedge usr_clk or negedge usr_rst_n) begin
    if (!usr_rst_n) begin
      m_sr <= '0; m_prev <= 1'b0;
    end else begin
      if (rd_shift)    m_sr <= m_sr << 1;
      else if (m_prev) m_sr <= rd_src ? exp_sig : golden_crc;
      m_prev <= !rd_shift;
    end
  end

  always @(negedge usr_clk)
    if (run && !done) check(rd_bit == m_sr[31], "R2 R3 R4 R5 per-cycle model", {31'd0, rd_bit}, {31'd0, m_sr[31]});

  task automatic read_word(input logic src, input int lowcyc, input bit tog,
                           input logic [31:0] exp, input string tag);
    logic [31:0] got;
    rd_shift = 1'b0; rd_src = src;
    repeat (lowcyc) @(negedge usr_clk);
    check(rd_bit == exp[31], "R9 MSB present after load", {31'd0, rd_bit}, {31'd0, exp[31]});
    for (int i = 31; i >= 0; i--) begin
      got[i] = rd_bit;
      rd_shift = 1'b1;
      if (tog) rd_src = ~rd_src;
      @(negedge usr_clk);
    end
    check(got == exp, tag, got, exp);
  endtask

  initial begin
    logic hold;
    rd_shift = 1'b1; rd_src = 1'b0; corrupt = 1'b0; run = 1'b0;
    chk_rst_n = 1'b0; usr_rst_n = 1'b0;
    golden_crc = ref_crc(1'b0);
    exp_sig = '0;
    repeat (3) @(negedge usr_clk);
    check(rd_bit == 1'b0, "R8 readout zero in reset", {31'd0, rd_bit}, 32'd0);
    check(crc_err == 1'b0, "R8 flag clear in reset", {31'd0, crc_err}, 32'd0);
    chk_rst_n = 1'b1; usr_rst_n = 1'b1; run = 1'b1;
    repeat (4) @(negedge usr_clk);
    read_word(1'b1, 2, 1'b0, 32'd0, "R8 signature cleared by reset");

    repeat (60) @(negedge usr_clk);
    check(crc_err == 1'b0, "R6 no error on clean image", {31'd0, crc_err}, 32'd0);
    read_word(1'b0, 2, 1'b1, golden_crc, "R3 R5 reference readout with select toggling");
    exp_sig = ref_crc(1'b0);
    read_word(1'b1, 2, 1'b0, exp_sig, "R1 R10 clean signature readout");
    read_word(1'b0, 5, 1'b0, golden_crc, "R3 long low hold reloads");

    // Single-cycle low pulse in the middle of a shift-out.
    read_word(1'b0, 2, 1'b0, golden_crc, "R3 reload before pulse test");
    rd_shift = 1'b0; rd_src = 1'b0; repeat (2) @(negedge usr_clk);
    rd_shift = 1'b1; repeat (3) @(negedge usr_clk);
    hold = rd_bit;
    rd_shift = 1'b0; rd_src = 1'b1; @(negedge usr_clk);
    check(rd_bit == hold && rd_bit == golden_crc[28], "R4 single low pulse holds", {31'd0, rd_bit}, {31'd0, golden_crc[28]});
    rd_shift = 1'b1; repeat (34) @(negedge usr_clk);
    check(rd_bit == 1'b0, "R2 zero fill after full shift-out", {31'd0, rd_bit}, 32'd0);

    corrupt = 1'b1;
    repeat (60) @(negedge usr_clk);
    check(crc_err == 1'b1, "R6 flag on corrupted image", {31'd0, crc_err}, 32'd1);
    exp_sig = ref_crc(1'b1);
    read_word(1'b1, 2, 1'b0, exp_sig, "R1 R10 corrupted signature readout");
    corrupt = 1'b0;
    repeat (60) @(negedge usr_clk);
    check(crc_err == 1'b1, "R7 flag sticky after repair", {31'd0, crc_err}, 32'd1);
    exp_sig = ref_crc(1'b0);
    read_word(1'b1, 2, 1'b0, exp_sig, "R1 signature restarts each pass");

    chk_rst_n = 1'b0; @(negedge usr_clk);
    check(crc_err == 1'b0, "R7 flag cleared by checker reset", {31'd0, crc_err}, 32'd0);
    chk_rst_n = 1'b1;
    repeat (60) @(negedge usr_clk);
    check(crc_err == 1'b0, "R6 stays clear after reset on clean image", {31'd0, crc_err}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule